// File: doc/BRIEF.md
# Memory Row Defect Classifier

This block grades the rows of a nibble-wide memory device while a test engine sweeps it. For every nibble it tests, the engine presents a 4-bit fail mask, and it marks the last nibble of each row. The block counts the faulty nibbles in the current row and compares that count with a tolerance that depends on the device geometry. It then sorts the row into one of three classes: clean (no faulty nibble), usable (some faulty nibbles, within tolerance) or bad (over tolerance). It keeps running totals of clean rows and bad rows.

When the last row of the selected geometry has been graded, the block pulses `done`. It raises `limit_err` if more than the permitted number of bad rows were found. A `start` pulse begins a new scan and captures the geometry.

The controller is a three-state machine:
- `ST_IDLE` waits for work.
- `ST_SCAN` accepts nibbles.
- `ST_DONE` lasts one cycle and drives `done`.

Its transitions are:
- start: from any state to `ST_SCAN`.
- final row end: from `ST_SCAN` to `ST_DONE`.
- retire: from `ST_DONE` to `ST_IDLE`, which is unconditional.

Top module: `rowscan_grader`

## Requirements
- R1: After reset, `clean_rows` and `bad_rows` are 0, and `done` and `limit_err` are low.
- R2: A nibble is faulty when at least one bit of `nib_mask` is 1 (1 means a failed bit). A single failing bit in any of the four positions makes the nibble faulty.
- R3: A row with no faulty nibble increments `clean_rows` by one, one cycle after its final nibble. A row is never counted as both clean and bad.
- R4: The tolerance depends on `geo_sel`. Code 0 (1024 rows) and code 2 (2048 rows) tolerate 4 faulty nibbles per row; code 1 (4096 rows) tolerates 16. A row above tolerance increments `bad_rows`. A row with 1 up to the tolerance counts in neither total.
- R5: A row with far more faulty nibbles than the tolerance (for example 40 with tolerance 4) is still counted as bad; the per-row count does not wrap.
- R6: `done` is high for exactly one cycle, one cycle after the final nibble of the last row of the captured geometry is accepted. Code 3 of `geo_sel` behaves like code 0 (1024 rows, tolerance 4).
- R7: `limit_err` rises in the same cycle as `done` if `bad_rows` exceeds 200; exactly 200 leaves it low. Once set, it holds until the next start.
- R8: After `done`, nibble strobes and row ends change neither count and produce no further `done` until the next start.
- R9: `start` clears both counts, the per-row faulty-nibble count and `limit_err`, and abandons any scan in progress. `geo_sel` is captured only in the start cycle.
- R10: `row_end` takes effect only together with `nib_vld`. On its own it does not close a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new scan; clears totals and captures geometry |
| geo_sel | input | 2 | Geometry code: 0 = 1024 rows, 1 = 4096 rows, 2 = 2048 rows, 3 = as 0 |
| nib_vld | input | 1 | A tested nibble is presented this cycle |
| nib_mask | input | 4 | Per-bit fail mask of the presented nibble (1 = failed) |
| row_end | input | 1 | The presented nibble is the last of its row |
| clean_rows | output | 13 | Rows with no faulty nibble in this scan |
| bad_rows | output | 13 | Rows above tolerance in this scan |
| done | output | 1 | One-cycle pulse after the last row |
| limit_err | output | 1 | Bad-row total exceeded 200 at the end of the scan |

## Verification
The hardest states to reach are those where the error limit matters: the bad-row total must sit exactly at 200, and one row later at 201, at the moment the final row of a full-size device closes. Only thousands of rows of stimulus get there. The bench builds these scans from a few helper tasks that emit whole rows with a chosen number of faulty nibbles. It fills the remaining rows with single clean nibbles, so that a complete 4096-row sweep stays short. A restart is also placed in the middle of a row that already holds faulty nibbles, so that a stale per-row count would push the next row over tolerance.

// File: rtl/rg_pkg.sv
package rg_pkg;

    // Geometry codes captured at start.
    typedef enum logic [1:0] {
        GEO_SQ1K   = 2'd0,
        GEO_TALL4K = 2'd1,
        GEO_SQ2K   = 2'd2,
        GEO_SPARE  = 2'd3
    } geo_e;

    // Scan controller states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl
    import rg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic nib_vld,
    input  logic row_end,
    input  logic last_row,
    output logic clear,
    output logic accept,
    output logic finish,
    output logic done
);

    scan_state_e state_q;
    scan_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, final row end, retire.
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SCAN: begin
                    if (nib_vld && row_end && last_row) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        clear  = start;
        accept = (state_q == ST_SCAN) && nib_vld && !start;
        finish = accept && row_end && last_row;
        done   = (state_q == ST_DONE);
    end

endmodule

// File: rtl/rg_nibble_tally.sv
module rg_nibble_tally #(
    parameter int TOL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic             row_end,
    input  logic [3:0]       mask,
    input  logic [TOL_W-1:0] tol,
    output logic             row_clean,
    output logic             row_bad
);

    logic [TOL_W-1:0] cnt_q;
    logic [TOL_W-1:0] cnt_eff;
    logic [TOL_W-1:0] sat_lvl;
    logic             nib_bad;

    always_comb begin
        nib_bad   = |mask;
        sat_lvl   = tol + TOL_W'(1);
        // Hold at tolerance plus one so long faulty rows cannot wrap.
        cnt_eff   = (cnt_q >= sat_lvl) ? sat_lvl : cnt_q + TOL_W'(nib_bad);
        row_clean = (cnt_eff == '0);
        row_bad   = (cnt_eff > tol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= row_end ? '0 : cnt_eff;
        end
    end

endmodule

// File: rtl/rg_row_stats.sv
module rg_row_stats #(
    parameter int ROW_W = 13,
    parameter int CNT_W = 13,
    parameter int LIMIT = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic             row_end,
    input  logic             row_clean,
    input  logic             row_bad,
    input  logic [ROW_W-1:0] rows_sel,
    output logic             last_row,
    output logic [CNT_W-1:0] clean_cnt,
    output logic [CNT_W-1:0] bad_cnt,
    output logic             err
);

    logic [ROW_W-1:0] row_idx;
    logic [CNT_W-1:0] bad_next;
    logic             row_done;

    always_comb begin
        row_done = accept && row_end;
        last_row = (row_idx == rows_sel - ROW_W'(1));
        bad_next = bad_cnt + CNT_W'(row_bad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx   <= '0;
            clean_cnt <= '0;
            bad_cnt   <= '0;
            err       <= 1'b0;
        end else if (clear) begin
            row_idx   <= '0;
            clean_cnt <= '0;
            bad_cnt   <= '0;
            err       <= 1'b0;
        end else if (row_done) begin
            row_idx   <= row_idx + ROW_W'(1);
            clean_cnt <= clean_cnt + CNT_W'(row_clean);
            bad_cnt   <= bad_next;
            if (last_row) begin
                err <= (bad_next > CNT_W'(LIMIT));
            end
        end
    end

endmodule

// File: rtl/rowscan_grader.sv
module rowscan_grader
    import rg_pkg::*;
#(
    parameter int G0_ROWS   = 1024,
    parameter int G0_TOL    = 4,
    parameter int G1_ROWS   = 4096,
    parameter int G1_TOL    = 16,
    parameter int G2_ROWS   = 2048,
    parameter int G2_TOL    = 4,
    parameter int BAD_LIMIT = 200,
    localparam int MAX_ROWS01 = (G0_ROWS > G1_ROWS) ? G0_ROWS : G1_ROWS,
    localparam int MAX_ROWS   = (MAX_ROWS01 > G2_ROWS) ? MAX_ROWS01 : G2_ROWS,
    localparam int MAX_TOL01  = (G0_TOL > G1_TOL) ? G0_TOL : G1_TOL,
    localparam int MAX_TOL    = (MAX_TOL01 > G2_TOL) ? MAX_TOL01 : G2_TOL,
    localparam int ROW_W      = $clog2(MAX_ROWS + 1),
    localparam int CNT_W      = ROW_W,
    localparam int TOL_W      = $clog2(MAX_TOL + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       geo_sel,
    input  logic             nib_vld,
    input  logic [3:0]       nib_mask,
    input  logic             row_end,
    output logic [CNT_W-1:0] clean_rows,
    output logic [CNT_W-1:0] bad_rows,
    output logic             done,
    output logic             limit_err
);

    geo_e             geo_q;
    logic [ROW_W-1:0] rows_sel;
    logic [TOL_W-1:0] tol_sel;
    logic             clear;
    logic             accept;
    logic             finish;
    logic             last_row;
    logic             row_clean;
    logic             row_bad;

    // Geometry is captured only in the start cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            geo_q <= GEO_SQ1K;
        end else if (start) begin
            geo_q <= geo_e'(geo_sel);
        end
    end

    always_comb begin
        unique case (geo_q)
            GEO_TALL4K: begin
                rows_sel = ROW_W'(G1_ROWS);
                tol_sel  = TOL_W'(G1_TOL);
            end
            GEO_SQ2K: begin
                rows_sel = ROW_W'(G2_ROWS);
                tol_sel  = TOL_W'(G2_TOL);
            end
            GEO_SQ1K, GEO_SPARE: begin
                rows_sel = ROW_W'(G0_ROWS);
                tol_sel  = TOL_W'(G0_TOL);
            end
            default: begin
                rows_sel = ROW_W'(G0_ROWS);
                tol_sel  = TOL_W'(G0_TOL);
            end
        endcase
    end

    rg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .nib_vld  (nib_vld),
        .row_end  (row_end),
        .last_row (last_row),
        .clear    (clear),
        .accept   (accept),
        .finish   (finish),
        .done     (done)
    );

    rg_nibble_tally #(
        .TOL_W (TOL_W)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .accept    (accept),
        .row_end   (row_end),
        .mask      (nib_mask),
        .tol       (tol_sel),
        .row_clean (row_clean),
        .row_bad   (row_bad)
    );

    rg_row_stats #(
        .ROW_W (ROW_W),
        .CNT_W (CNT_W),
        .LIMIT (BAD_LIMIT)
    ) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .accept    (accept),
        .row_end   (row_end),
        .row_clean (row_clean),
        .row_bad   (row_bad),
        .rows_sel  (rows_sel),
        .last_row  (last_row),
        .clean_cnt (clean_rows),
        .bad_cnt   (bad_rows),
        .err       (limit_err)
    );

    logic finish_unused;
    assign finish_unused = finish;

endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             nib_vld,
    input logic             row_end,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] clean_cnt,
    input logic [CNT_W-1:0] bad_cnt
);

    logic after_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            after_done <= 1'b0;
        end else if (start) begin
            after_done <= 1'b0;
        end else if (done) begin
            after_done <= 1'b1;
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (clean_cnt == '0 && bad_cnt == '0 && !err && !done));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    assert_err_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    assert_row_end_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(nib_vld && row_end)) |=> ($stable(clean_cnt) && $stable(bad_cnt)));

    assert_single_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(clean_cnt) || $stable(bad_cnt)));

    assert_clean_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (clean_cnt == $past(clean_cnt) || clean_cnt == $past(clean_cnt) + CNT_W'(1)));

    assert_bad_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (bad_cnt == $past(bad_cnt) || bad_cnt == $past(bad_cnt) + CNT_W'(1)));

    assert_frozen_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (after_done && !start) |=> ($stable(clean_cnt) && $stable(bad_cnt) && !done));

endmodule

bind rowscan_grader rg_checker #(.CNT_W(CNT_W)) u_rg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .nib_vld   (nib_vld),
    .row_end   (row_end),
    .done      (done),
    .err       (limit_err),
    .clean_cnt (clean_rows),
    .bad_cnt   (bad_rows)
);

// File: tb/rowscan_grader_test.sv
module rowscan_grader_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 13;
    localparam int LIMIT      = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    geo_sel = 2'd0;
    logic          nib_vld = 1'b0;
    logic [3:0]    nib_mask = 4'd0;
    logic          row_end = 1'b0;
    logic [CW-1:0] clean_rows;
    logic [CW-1:0] bad_rows;
    logic          done;
    logic          limit_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    rowscan_grader uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .geo_sel    (geo_sel),
        .nib_vld    (nib_vld),
        .nib_mask   (nib_mask),
        .row_end    (row_end),
        .clean_rows (clean_rows),
        .bad_rows   (bad_rows),
        .done       (done),
        .limit_err  (limit_err)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [2*CW:0] exp_q[$];
    logic [2*CW:0] mon_e;
    int exp_clean, exp_bad, rows_seen, cur_rows, cur_tol, cur_bad_nib;
    bit prev_done = 1'b0;

    task automatic chk(string req, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        nib_vld  = 1'b0;
        row_end  = 1'b0;
        nib_mask = 4'd0;
        start    = 1'b0;
    endtask

    task automatic do_start(int g);
        @(negedge clk);
        start   = 1'b1;
        geo_sel = g[1:0];
        nib_vld = 1'b0;
        row_end = 1'b0;
        cur_rows    = (g == 1) ? 4096 : (g == 2) ? 2048 : 1024;
        cur_tol     = (g == 1) ? 16 : 4;
        exp_clean   = 0;
        exp_bad     = 0;
        rows_seen   = 0;
        cur_bad_nib = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Driver: one live nibble; model the row class and queue the end result.
    task automatic nib(logic [3:0] m, bit last);
        @(negedge clk);
        nib_vld  = 1'b1;
        nib_mask = m;
        row_end  = last;
        if (m != 4'd0) cur_bad_nib++;
        if (last) begin
            if (cur_bad_nib == 0) exp_clean++;
            else if (cur_bad_nib > cur_tol) exp_bad++;
            cur_bad_nib = 0;
            rows_seen++;
            if (rows_seen == cur_rows)
                exp_q.push_back({(exp_bad > LIMIT) ? 1'b1 : 1'b0, CW'(exp_clean), CW'(exp_bad)});
        end
    endtask

    task automatic row(int nbad, int ngood, logic [3:0] bm);
        for (int i = 0; i < nbad + ngood; i++)
            nib((i < nbad) ? bm : 4'd0, i == nbad + ngood - 1);
    endtask

    task automatic fill(int n, bit bad);
        for (int i = 0; i < n; i++) begin
            if (bad) row(cur_tol + 1, 0, 4'b0101);
            else     row(0, 1, 4'd0);
        end
    endtask

    task automatic counts(string req);
        chk({req, " clean"}, int'(clean_rows), exp_clean);
        chk({req, " bad"}, int'(bad_rows), exp_bad);
    endtask

    // Monitor: pop expected end-of-scan results as done appears.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) begin
                if (prev_done) begin
                    chk("R6 done longer than one cycle", 1, 0);
                end else if (exp_q.size() == 0) begin
                    chk("R6 unexpected done", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk("R7 limit_err at done", int'(limit_err), int'(mon_e[2*CW]));
                    chk("R3 clean_rows at done", int'(clean_rows), int'(mon_e[2*CW-1:CW]));
                    chk("R4 bad_rows at done", int'(bad_rows), int'(mon_e[CW-1:0]));
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL R6 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset clean", int'(clean_rows), 0);
        chk("R1 reset bad", int'(bad_rows), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset err", int'(limit_err), 0);
        rst_n = 1'b1;

        // Scan A: 1024 rows, tolerance 4, exactly 200 bad rows.
        do_start(0);
        counts("R9 after start");
        row(0, 3, 4'd0);
        idle();
        counts("R3 clean row");
        for (int b = 0; b < 4; b++) begin
            row(1, 0, 4'(1 << b));
            idle();
            counts("R2 single fail bit");
        end
        nib(4'd0, 1'b0);
        @(negedge clk);
        nib_vld = 1'b0;
        row_end = 1'b1;
        nib(4'b0010, 1'b1);
        idle();
        counts("R10 lone row_end");
        row(4, 0, 4'b1111);
        idle();
        counts("R4 at tolerance");
        row(5, 0, 4'b0011);
        idle();
        counts("R4 above tolerance");
        row(40, 0, 4'b1000);
        idle();
        counts("R5 saturation");
        fill(198, 1'b1);
        fill(1024 - 9 - 198, 1'b0);
        idle();
        chk("R6 done after last row", int'(done), 1);
        chk("R7 exactly limit no error", int'(limit_err), 0);
        idle();
        chk("R6 done one cycle", int'(done), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            nib_vld  = 1'b1;
            nib_mask = 4'hF;
            row_end  = 1'b1;
        end
        idle();
        counts("R8 ignored after done");
        chk("R8 no second done", int'(done), 0);

        // Scan B: 4096 rows, tolerance 16, 201 bad rows; geo changed mid-scan.
        do_start(1);
        geo_sel = 2'd0;
        row(16, 0, 4'b0100);
        idle();
        counts("R4 tall tolerance");
        row(17, 0, 4'b0100);
        idle();
        counts("R4 tall above tolerance");
        fill(200, 1'b1);
        fill(4096 - 202, 1'b0);
        idle();
        chk("R9 geometry held done", int'(done), 1);
        chk("R7 over limit error", int'(limit_err), 1);
        idle();
        idle();
        chk("R7 error holds", int'(limit_err), 1);

        // Scan C: 2048 rows, with an abort in the middle of a faulty row.
        do_start(2);
        chk("R9 start clears error", int'(limit_err), 0);
        counts("R9 start clears counts");
        row(5, 0, 4'b1001);
        fill(10, 1'b0);
        idle();
        counts("R9 before abort");
        nib(4'b1111, 1'b0);
        nib(4'b1111, 1'b0);
        nib(4'b1111, 1'b0);
        do_start(2);
        counts("R9 abort clears counts");
        row(2, 0, 4'b0001);
        idle();
        counts("R9 per-row count cleared");
        row(5, 0, 4'b0100);
        fill(2046, 1'b0);
        idle();
        chk("R6 done for 2048 rows", int'(done), 1);
        idle();
        chk("R6 done low after pulse", int'(done), 0);

        // Scan D: code 3 behaves like code 0.
        do_start(3);
        fill(1023, 1'b0);
        row(5, 0, 4'b1000);
        idle();
        chk("R6 code 3 done at 1024 rows", int'(done), 1);
        idle();
        idle();

        chk("R6 all scans completed", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule